// File: doc/BRIEF.md
# LFSR-Addressed Display Line Buffer

This block is a 48-byte on-chip buffer that holds the display bytes of one text or graphics row. On the first scanline of a row the fetch engine hands it one byte per advance strobe and the buffer stores them. On each later scanline of that row the same strobes replay the bytes in the same order, so external memory is read only once per row.

The row pointer is not a binary counter. It is a 6-bit shift register with linear feedback (polynomial x^6 + x^5 + 1), which needs less logic than an incrementer. Its state space (63 states) is larger than the 48 storage rows, so the row decoder matches the exact states visited after the seed and maps the k-th visited state to physical row k. The state reached after 48 steps is not in the decoder, and that miss is what halts the pointer until the next line start.

Top module: `lb_line_buffer`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 0 and the pointer returns to the seed, so the first strobe after reset addresses row 0. Reset does not clear the stored bytes.
- R2: A `line_start` pulse reseeds the pointer to 6'b000001, so the next accepted strobe addresses row 0.
- R3: The pointer steps as next = {s[4:0], s[5]^s[4]}. The k-th state visited after the seed (k = 0..47) selects row k, so bytes replay in the order in which they were written.
- R4: An `adv` strobe with `first_line` high stores `wr_data` in the current row and steps the pointer.
- R5: An `adv` strobe with `first_line` low steps the pointer, and on the next clock edge `rd_data` shows the byte of the row it addressed (one cycle of latency).
- R6: `rd_data` changes only after an accepted read strobe. It holds through idle cycles and write strobes.
- R7: After 48 accepted strobes since the last line start, further strobes are ignored. Nothing is written, the pointer does not move, and `rd_data` holds.
- R8: When `line_start` and `adv` are high in the same cycle, the line start wins. The strobe writes nothing, reads nothing, does not step the pointer, and `rd_data` holds.
- R9: `first_line` is sampled on every strobe, so a line may mix writes and reads. Each strobe acts on the row it addresses.
- R10: Stored bytes persist across line starts and resets until the same row is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Reseeds the row pointer at the start of a scanline |
| first_line | input | 1 | High: strobes store bytes; low: strobes replay bytes |
| adv | input | 1 | Advance strobe, one byte per pulse |
| wr_data | input | 8 | Byte to store on a first-line strobe |
| rd_data | output | 8 | Registered replay byte |

## Verification
The two actions that can fall in the same cycle are the line-start reseed and an advance strobe. The bench raises both together in a store line and again in the middle of a replay line. It judges the result at the ports: `rd_data` must not move in the collision cycle, and the next replay line must still return the byte that was in row 0 before the collision. Exhaustion is provoked by strobing past 48 in both modes, with different data on the extra writes, and then replaying the whole buffer.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int LFSR_W = 6;
  localparam int LFSR_PERIOD = (1 << LFSR_W) - 1;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 6'b110000;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 6'b000001;

  // one shift of the pointer: feedback from the tapped bits enters at bit 0
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
  endfunction

  // state of the pointer after k steps from the seed
  function automatic logic [LFSR_W-1:0] lfsr_state_at(input int k);
    logic [LFSR_W-1:0] s;
    s = LFSR_SEED;
    for (int i = 0; i < LFSR_PERIOD; i++) begin
      if (i < k) s = lfsr_step(s);
    end
    return s;
  endfunction
endpackage

// File: rtl/lb_lfsr.sv
module lb_lfsr
  import lb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= LFSR_SEED;
    else if (restart) state <= LFSR_SEED;
    else if (step)    state <= lfsr_step(state);
  end
endmodule

// File: rtl/lb_row_decode.sv
module lb_row_decode
  import lb_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int ROW_W = 6
) (
  input  logic [LFSR_W-1:0] state,
  output logic [DEPTH-1:0]  sel,
  output logic [ROW_W-1:0]  idx,
  output logic              hit
);
  // one comparator per physical row, matched against the state visited k-th
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    localparam logic [LFSR_W-1:0] ROW_STATE = lfsr_state_at(g);
    assign sel[g] = (state == ROW_STATE);
  end

  always_comb begin
    idx = '0;
    for (int g = 0; g < DEPTH; g++) begin
      if (sel[g]) idx = idx | ROW_W'(g);
    end
  end

  assign hit = |sel;
endmodule

// File: rtl/lb_store.sv
module lb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 48,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/lb_line_buffer.sv
module lb_line_buffer
  import lb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              first_line,
  input  logic              adv,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ROW_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LFSR_W-1:0] lfsr_q;
  logic [DEPTH-1:0]  row_sel;
  logic [ROW_W-1:0]  row_idx;
  logic              row_hit;
  logic              step_ok;
  logic              wr_fire;
  logic              rd_fire;

  // a line start overrides any strobe; a decoder miss means the line is used up
  assign step_ok = adv & ~line_start & row_hit;
  assign wr_fire = step_ok & first_line;
  assign rd_fire = step_ok & ~first_line;

  lb_lfsr u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (line_start),
    .step    (step_ok),
    .state   (lfsr_q)
  );

  lb_row_decode #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_dec (
    .state (lfsr_q),
    .sel   (row_sel),
    .idx   (row_idx),
    .hit   (row_hit)
  );

  lb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ROW_W(ROW_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .re    (rd_fire),
    .addr  (row_idx),
    .wdata (wr_data),
    .rdata (rd_data)
  );
endmodule

// File: rtl/lb_line_buffer_chk.sv
module lb_line_buffer_chk
  import lb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 48,
  parameter int ROW_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              adv,
  input logic [DATA_W-1:0] rd_data,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic [DEPTH-1:0]  row_sel,
  input logic [ROW_W-1:0]  row_idx,
  input logic              row_hit,
  input logic              wr_fire,
  input logic              rd_fire
);
  logic accepted;
  assign accepted = adv && !line_start && row_hit;

  // R2
  reseed_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (row_hit && row_idx == '0));

  // R3
  row_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && row_idx < ROW_W'(DEPTH-1)) |=> (row_hit && row_idx == $past(row_idx) + 1'b1));

  // R3
  single_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  // R7
  last_row_exhausts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && row_idx == ROW_W'(DEPTH-1)) |=> !row_hit);

  // R7
  exhausted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_hit && !line_start) |=> $stable(lfsr_q));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));

  // R8
  collision_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (!wr_fire && !rd_fire));

  // R9
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && rd_fire));
endmodule

bind lb_line_buffer lb_line_buffer_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .ROW_W  (ROW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_start (line_start),
  .adv        (adv),
  .rd_data    (rd_data),
  .lfsr_q     (lfsr_q),
  .row_sel    (row_sel),
  .row_idx    (row_idx),
  .row_hit    (row_hit),
  .wr_fire    (wr_fire),
  .rd_fire    (rd_fire)
);

// File: tb/sim_lb_line_buffer.sv
module sim_lb_line_buffer;
  localparam int N = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic       first_line = 1'b0;
  logic       adv = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model_mem [N];
  int         pos = 0;
  logic [7:0] exp_rd = '0;

  always #4 clk = ~clk;

  lb_line_buffer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .first_line (first_line),
    .adv        (adv),
    .wr_data    (wr_data),
    .rd_data    (rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // reseed, optionally with a colliding strobe (R8: the strobe must have no effect)
  task automatic new_line(input bit with_adv, input bit fl, input logic [7:0] d);
    @(negedge clk);
    line_start = 1'b1; adv = with_adv; first_line = fl; wr_data = d;
    @(posedge clk); #1;
    pos = 0;
    chk(with_adv ? "R8" : "R2", rd_data, exp_rd);
    @(negedge clk);
    line_start = 1'b0; adv = 1'b0;
  endtask

  // one advance strobe followed by one idle cycle
  task automatic strobe(input bit fl, input logic [7:0] d, input string req);
    @(negedge clk);
    adv = 1'b1; first_line = fl; wr_data = d;
    @(posedge clk); #1;
    if (pos < N) begin
      if (fl) model_mem[pos] = d;
      else    exp_rd = model_mem[pos];
      pos++;
    end
    chk(req, rd_data, exp_rd);
    @(negedge clk);
    adv = 1'b0;
    @(posedge clk); #1;
    chk("R6", rd_data, exp_rd);
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 37 + i * 11 + 5) % 256);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", rd_data, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    // full store line, then two replay lines, with overrun in both modes
    for (int p = 0; p < 4; p++) begin
      new_line(1'b0, 1'b1, 8'h00);
      for (int i = 0; i < N; i++) strobe(1'b1, pat(p, i), "R4");
      strobe(1'b1, 8'hA5, "R7");
      strobe(1'b1, 8'h5A, "R7");
      for (int r = 0; r < 2; r++) begin
        new_line(1'b0, 1'b0, 8'h00);
        for (int i = 0; i < N; i++) strobe(1'b0, 8'h00, "R5 order R3");
        for (int k = 0; k < 3; k++) strobe(1'b0, 8'h00, "R7");
      end
    end

    // partial store line: the remaining rows keep old bytes (R10)
    new_line(1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 10; i++) strobe(1'b1, 8'(200 + i), "R4");
    new_line(1'b0, 1'b0, 8'h00);
    for (int i = 0; i < N; i++) strobe(1'b0, 8'h00, "R10");

    // collision in a store line: row 0 must not be written (R8)
    new_line(1'b1, 1'b1, 8'hEE);
    strobe(1'b1, 8'h3C, "R4");
    new_line(1'b1, 1'b1, 8'hEE);
    new_line(1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 3; i++) strobe(1'b0, 8'h00, "R8");
    // collision in the middle of a replay line
    new_line(1'b1, 1'b0, 8'h00);
    for (int i = 0; i < N; i++) strobe(1'b0, 8'h00, "R8");

    // mixed line: first_line honoured per strobe (R9)
    new_line(1'b0, 1'b1, 8'h00);
    for (int i = 0; i < N; i++) begin
      if (i % 2 == 0) strobe(1'b1, 8'(i * 5 + 1), "R9");
      else            strobe(1'b0, 8'h00, "R9");
    end
    new_line(1'b0, 1'b0, 8'h00);
    for (int i = 0; i < N; i++) strobe(1'b0, 8'h00, "R9");

    // reset in mid-line: output cleared, pointer back at row 0, bytes kept (R1, R10)
    new_line(1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 5; i++) strobe(1'b0, 8'h00, "R5");
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    exp_rd = 8'h00;
    pos = 0;
    chk("R1", rd_data, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 4; i++) strobe(1'b0, 8'h00, "R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule